// File: doc/BRIEF.md
# Timer Overflow Status Register

This block is the status and interrupt-enable register for a timer with three 16-bit counting channels. The counters stay outside it. Each channel supplies a one-cycle pulse when its counter wraps upward from 0xFFFF to 0x0000. Channel 2 also supplies a pulse when it wraps downward from 0x0000 to 0xFFFF. The block latches these events into sticky per-channel flags. It combines each flag with an enable bit to form a level interrupt request for that channel.

Software reaches the block through a single 8-bit register with a synchronous read/write port. Read data shows the current register contents in the same cycle. A flag cannot be cleared by a blind write. Software must first read the register while that flag is 1, which arms the bit. Only then does a later write of 0 to that bit clear it. Any write disarms every bit, so each clear needs a fresh read.

The layout is: bit 7 reads 1, bits 6/5/4 are the enables for channels 2/1/0, bit 3 reads 1, and bits 2/1/0 are the flags for channels 2/1/0.

Top module: `ovf_status_reg`

## Requirements
- R1: After synchronous reset, all flags and enables are 0. Read data is 0x88 and all interrupt requests are low.
- R2: Bits 7 and 3 always read as 1, whatever value was written to them.
- R3: An overflow pulse on channel i sets flag bit i (bit 0, 1 or 2), and the flag is visible in read data on the cycle after the pulse.
- R4: An underflow pulse sets flag bit 2 only while the phase counting mode input is 1. With that input at 0 the pulse leaves flag bit 2 unchanged.
- R5: A write with 0 in flag bit i clears that flag only if the bit was armed. A bit is armed by an earlier read, with no write in between, that saw the flag at 1. An unarmed flag stays 1.
- R6: Writing 1 to a flag bit never sets the flag and never clears it.
- R7: Every write disarms all flag bits. A read, then a write that leaves a flag set, then a write of 0 to that flag, leaves the flag at 1.
- R8: When an event for channel i and a valid clearing write of bit i fall in the same cycle, flag i ends at 1.
- R9: A write loads bits 6, 5 and 4 into the enables of channels 2, 1 and 0. The enables read back at those positions and hold between writes.
- R10: Interrupt request i is high exactly while flag i and enable i are both 1.
- R11: When read and write strobes are both high in one cycle, the write uses the arming state from before that cycle, and that read arms nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Register read strobe (arms flags that read as 1) |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current register contents |
| ovf_pulse | input | 3 | Per-channel upward wrap pulse |
| unf_pulse | input | 1 | Channel 2 downward wrap pulse |
| phase_mode | input | 1 | Channel 2 phase counting mode |
| irq | output | 3 | Per-channel interrupt request |

## Verification
The bench first sends each channel's overflow pulse alone, to show that each event lands only in its own bit. It sends the underflow pulse with the mode input low and then high, to tell the gated case from the accepted one. Clearing is tried three ways: a blind write, a write after a read, and a write after a read followed by a disarming write. This separates arming from plain write-zero behaviour. Same-cycle collisions come last, to show that set beats clear and that a simultaneous read does not arm. In these, an event meets a clearing write, or a read meets a write.

// File: rtl/ovf_status_pkg.sv
package ovf_status_pkg;

    localparam int unsigned NUM_CH  = 3;
    localparam int unsigned REG_W   = 8;
    localparam int unsigned FLAG_LO = 0;
    localparam int unsigned EN_LO   = 4;
    localparam int unsigned RSV_LO  = 3;
    localparam int unsigned RSV_HI  = 7;
    localparam int unsigned UNF_CH  = 2;

    typedef struct packed {
        logic             rd;
        logic             wr;
        logic [REG_W-1:0] data;
    } bus_req_t;

    function automatic logic [REG_W-1:0] pack_view(
        input logic [NUM_CH-1:0] flags,
        input logic [NUM_CH-1:0] ens
    );
        logic [REG_W-1:0] v;
        v = '0;
        v[RSV_HI] = 1'b1;
        v[RSV_LO] = 1'b1;
        v[EN_LO   +: NUM_CH] = ens;
        v[FLAG_LO +: NUM_CH] = flags;
        return v;
    endfunction

endpackage

// File: rtl/ovf_flag_cell.sv
module ovf_flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wbit_i,
    input  logic set_i,
    output logic flag_o
);
    logic flag_q;
    logic armed_q;
    logic clr_ok;

    assign clr_ok = wr_i && !wbit_i && armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end else if (clr_ok) begin
            flag_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else if (wr_i) begin
            armed_q <= 1'b0;
        end else if (rd_i && flag_q) begin
            armed_q <= 1'b1;
        end
    end

    assign flag_o = flag_q;

    // R3: an event always leaves the flag set
    a_r3_event_sets: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_q);
    // R6: no event and flag clear means the flag stays clear
    a_r6_no_sw_set: assert property (@(posedge clk) disable iff (rst)
        (!set_i && !flag_q) |=> !flag_q);
    // R5: an unarmed flag survives any write
    a_r5_unarmed_holds: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !armed_q) |=> flag_q);
    // R7: a write leaves the bit disarmed
    a_r7_write_disarms: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> !armed_q);
    // R8: set beats a legal clear
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        (set_i && wr_i && !wbit_i && armed_q) |=> flag_q);

endmodule

// File: rtl/ovf_enable_reg.sv
module ovf_enable_reg #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] en_o
);
    logic [N-1:0] en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (wr_i) begin
            en_q <= wdata_i;
        end
    end

    assign en_o = en_q;

    // R9: enables change only on a write
    a_r9_enable_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> $stable(en_q));

endmodule

// File: rtl/ovf_status_reg.sv
module ovf_status_reg
    import ovf_status_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic [NUM_CH-1:0] ovf_pulse,
    input  logic             unf_pulse,
    input  logic             phase_mode,
    output logic [NUM_CH-1:0] irq
);
    bus_req_t          req;
    logic [NUM_CH-1:0] set_evt;
    logic [NUM_CH-1:0] flags;
    logic [NUM_CH-1:0] ens;
    logic              unused_rsv_bits;

    assign req = '{rd: rd_en, wr: wr_en, data: wr_data};
    assign unused_rsv_bits = ^{req.data[RSV_HI], req.data[RSV_LO]};

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        if (i == UNF_CH) begin : g_updown
            assign set_evt[i] = ovf_pulse[i] | (unf_pulse & phase_mode);
        end else begin : g_up
            assign set_evt[i] = ovf_pulse[i];
        end

        ovf_flag_cell u_flag (
            .clk    (clk),
            .rst    (rst),
            .rd_i   (req.rd),
            .wr_i   (req.wr),
            .wbit_i (req.data[FLAG_LO + i]),
            .set_i  (set_evt[i]),
            .flag_o (flags[i])
        );
    end

    ovf_enable_reg #(.N(NUM_CH)) u_en (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (req.wr),
        .wdata_i (req.data[EN_LO +: NUM_CH]),
        .en_o    (ens)
    );

    assign rd_data = pack_view(flags, ens);
    assign irq     = flags & ens;

    // R4: underflow without phase mode cannot raise a clear channel 2 flag
    a_r4_unf_gated: assert property (@(posedge clk) disable iff (rst)
        (unf_pulse && !phase_mode && !ovf_pulse[UNF_CH] && !rd_data[FLAG_LO + UNF_CH])
        |=> !rd_data[FLAG_LO + UNF_CH]);
    // R10: a request rises only after both flag and enable are present
    a_r10_irq_needs_en: assert property (@(posedge clk) disable iff (rst)
        (irq[0] |-> rd_data[EN_LO]));
    // R1: the cycle after reset shows the reset view
    a_r1_reset_view: assert property (@(posedge clk)
        rst |=> (rd_data == 8'h88 || $past(ovf_pulse) != '0 || $past(wr_en)));

endmodule

// File: tb/ovf_status_reg_bench.sv
module ovf_status_reg_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 16;

    logic       clk = 1'b0;
    logic       rst;
    logic       rd_en, wr_en, unf_pulse, phase_mode;
    logic [7:0] wr_data, rd_data;
    logic [2:0] ovf_pulse, irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ovf_status_reg u_ovf_status_reg (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .ovf_pulse(ovf_pulse), .unf_pulse(unf_pulse),
        .phase_mode(phase_mode), .irq(irq)
    );

    // fields: ovf[3] unf ph rd wr wdata[8] exp_rd[8] exp_irq[3]
    localparam logic [25:0] VECS [0:NV-1] = '{
        {3'b001,1'b0,1'b0,1'b0,1'b0,8'h00,8'h89,3'b000}, // R3 ch0
        {3'b000,1'b0,1'b0,1'b0,1'b1,8'h70,8'hF9,3'b001}, // R5 blind, R9, R10
        {3'b010,1'b0,1'b0,1'b0,1'b0,8'h00,8'hFB,3'b011}, // R3 ch1
        {3'b000,1'b1,1'b0,1'b0,1'b0,8'h00,8'hFB,3'b011}, // R4 gated
        {3'b000,1'b1,1'b1,1'b0,1'b0,8'h00,8'hFF,3'b111}, // R4 accepted
        {3'b000,1'b0,1'b0,1'b1,1'b0,8'h00,8'hFF,3'b111}, // read arms
        {3'b000,1'b0,1'b0,1'b0,1'b1,8'h7E,8'hFE,3'b110}, // R5 clear, R6
        {3'b000,1'b0,1'b0,1'b0,1'b1,8'h78,8'hFE,3'b110}, // R7
        {3'b000,1'b0,1'b0,1'b1,1'b0,8'h00,8'hFE,3'b110}, // rearm
        {3'b100,1'b0,1'b0,1'b0,1'b1,8'h70,8'hFC,3'b100}, // R8
        {3'b000,1'b0,1'b0,1'b0,1'b1,8'h00,8'h8C,3'b000}, // R9, R10
        {3'b000,1'b0,1'b0,1'b0,1'b1,8'hFF,8'hFC,3'b100}, // R2, R6
        {3'b000,1'b0,1'b0,1'b1,1'b1,8'h70,8'hFC,3'b100}, // R11 same cycle
        {3'b000,1'b0,1'b0,1'b0,1'b1,8'h70,8'hFC,3'b100}, // R11 no arm
        {3'b000,1'b0,1'b0,1'b1,1'b0,8'h00,8'hFC,3'b100}, // arm
        {3'b000,1'b0,1'b0,1'b0,1'b1,8'h00,8'h88,3'b000}  // R5 final clear
    };
    localparam string VREQ [0:NV-1] = '{"R3","R5","R3","R4","R4","R5","R5","R7",
                                        "R5","R8","R9","R2","R11","R11","R5","R5"};

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        rd_en = 0; wr_en = 0; wr_data = 8'h00;
        ovf_pulse = 3'b000; unf_pulse = 0; phase_mode = 0;
    endtask

    initial begin
        idle();
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        check("R1", rd_data, 8'h88);
        check("R1", {5'b0, irq}, 8'h00);

        for (int k = 0; k < NV; k++) begin
            {ovf_pulse, unf_pulse, phase_mode, rd_en, wr_en, wr_data} = VECS[k][25:11];
            @(negedge clk);
            check(VREQ[k], rd_data, VECS[k][10:3]);
            check("R10", {5'b0, irq}, {5'b0, VECS[k][2:0]});
            idle();
        end

        // directed: all flags and enables set, then reset mid-run (R1)
        ovf_pulse = 3'b111; wr_en = 1; wr_data = 8'h70;
        @(negedge clk);
        idle();
        check("R3", rd_data, 8'hFF);
        rst = 1;
        @(negedge clk);
        rst = 0;
        check("R1", rd_data, 8'h88);
        check("R1", {5'b0, irq}, 8'h00);

        // R4: underflow alone with mode high from clean state
        unf_pulse = 1; phase_mode = 1;
        @(negedge clk);
        idle();
        check("R4", rd_data, 8'h8C);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule